// File: doc/BRIEF.md
# Transmit Completion and Auto-Release Manager

This block keeps an ordered queue of packet numbers waiting to be sent and decides what happens to each one when the transmitter reports that it has finished. The packet at the head of the queue is offered to the transmitter while transmission is enabled. The transmitter answers with a done event that carries one flag: success or fatal error.

A mode input selects between two behaviours. With auto-release off, each finished packet number goes into a completion FIFO together with its outcome. The CPU reads these entries and frees the buffers itself. With auto-release on, a successful packet has its buffer pages freed at once through a release request. No status is kept for it and it produces no per-packet interrupt. Only the end of the whole queued run raises the transmit-empty interrupt.

In either mode, a fatal error halts the run. Transmission is disabled, the failing packet stays at the head with its pages kept, and its number is shown on the fault outputs. When the CPU enables transmission again, sending resumes with that same packet.

Top module: `tx_autorel_mgr`

## Requirements
- R1: The queue holds up to 16 packet numbers of 6 bits in arrival order and exposes full and empty flags. An enqueue while the queue is full is ignored.
- R2: `cur_valid` is high exactly when transmission is enabled and the queue is not empty. `cur_pnum` shows the head packet number, or 0 when the queue is empty.
- R3: In auto-release mode a successful done removes the head packet. On the next cycle `rel_valid` pulses for one cycle with that packet number on `rel_pnum`, and nothing is written to the completion FIFO.
- R4: With auto-release off, every accepted done writes the head packet number and its outcome (`cf_ok` 1 = success, 0 = fatal) into the completion FIFO. Entries come out in order, and no release request is issued.
- R5: `irq_tx` is high while the completion FIFO holds an entry or a fatal error is pending.
- R6: A fatal done clears transmit enable and keeps the failing packet at the head with no release request. It raises `fault_valid` with that packet on `fault_pnum`.
- R7: A `tx_en_set` pulse sets transmit enable and clears the pending fault, and transmission resumes with the packet that failed.
- R8: `irq_empty` is set when a successful done removes the last queued packet. It stays high until `empty_ack` or an accepted enqueue clears it.
- R9: In auto-release mode a run of successful packets leaves `irq_tx` low.
- R10: A done event while `cur_valid` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_rel | input | 1 | 1 = auto-release mode |
| enq_valid | input | 1 | Enqueue a packet number |
| enq_pnum | input | 6 | Packet number to enqueue |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| tx_en_set | input | 1 | CPU pulse that enables transmission |
| tx_en | output | 1 | Transmit enable state |
| cur_valid | output | 1 | Head packet is offered to the transmitter |
| cur_pnum | output | 6 | Head packet number |
| done_valid | input | 1 | Transmission of the head packet has ended |
| done_ok | input | 1 | 1 = success, 0 = fatal error |
| rel_valid | output | 1 | Page-release request |
| rel_pnum | output | 6 | Packet whose pages are released |
| cf_valid | output | 1 | Completion FIFO not empty |
| cf_pnum | output | 6 | Packet number of the oldest completion entry |
| cf_ok | output | 1 | Outcome of the oldest completion entry |
| cf_pop | input | 1 | Remove the oldest completion entry |
| irq_tx | output | 1 | Transmit interrupt |
| irq_empty | output | 1 | Transmit-empty interrupt |
| empty_ack | input | 1 | CPU acknowledge of the transmit-empty interrupt |
| fault_valid | output | 1 | A fatal error is pending |
| fault_pnum | output | 6 | Packet number that failed |

## Verification
Every result is registered. The queue, the FIFO, transmit enable, the fault state, both interrupts and the release pulse all change on the clock edge that takes the stimulus, so they are due one edge later. `cur_valid` and `cur_pnum` follow combinationally from those registers. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and then samples on the next falling edge. A release pulse can therefore be seen on the step after its done, and its absence one step later.

// File: rtl/tx_autorel_mgr.sv
module tx_autorel_mgr #(
  parameter int PNUM_W = 6,
  parameter int QDEPTH = 16,
  parameter int CDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_rel,
  input  logic              enq_valid,
  input  logic [PNUM_W-1:0] enq_pnum,
  output logic              q_full,
  output logic              q_empty,
  input  logic              tx_en_set,
  output logic              tx_en,
  output logic              cur_valid,
  output logic [PNUM_W-1:0] cur_pnum,
  input  logic              done_valid,
  input  logic              done_ok,
  output logic              rel_valid,
  output logic [PNUM_W-1:0] rel_pnum,
  output logic              cf_valid,
  output logic [PNUM_W-1:0] cf_pnum,
  output logic              cf_ok,
  input  logic              cf_pop,
  output logic              irq_tx,
  output logic              irq_empty,
  input  logic              empty_ack,
  output logic              fault_valid,
  output logic [PNUM_W-1:0] fault_pnum
);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CAW = (CDEPTH > 1) ? $clog2(CDEPTH) : 1;

  logic [PNUM_W-1:0] q_mem [QDEPTH];
  logic [QAW-1:0]    q_wp, q_rp;
  logic [QAW:0]      q_cnt;
  logic [PNUM_W:0]   c_mem [CDEPTH];
  logic [CAW-1:0]    c_wp, c_rp;
  logic [CAW:0]      c_cnt;
  logic              fault;

  assign q_full    = q_cnt == (QAW+1)'(QDEPTH);
  assign q_empty   = q_cnt == '0;
  assign cur_valid = tx_en && !q_empty;
  assign cur_pnum  = q_empty ? '0 : q_mem[q_rp];

  wire q_push = enq_valid && !q_full;
  wire fire   = done_valid && cur_valid;
  wire q_pop  = fire && done_ok;
  wire c_full = c_cnt == (CAW+1)'(CDEPTH);
  wire c_push = fire && !auto_rel && !c_full;
  wire c_take = cf_pop && cf_valid;

  assign cf_valid    = c_cnt != '0;
  assign cf_pnum     = c_mem[c_rp][PNUM_W-1:0];
  assign cf_ok       = c_mem[c_rp][PNUM_W];
  assign irq_tx      = cf_valid || fault;
  assign fault_valid = fault;
  assign fault_pnum  = cur_pnum;

  always_ff @(posedge clk) begin
    if (q_push) q_mem[q_wp] <= enq_pnum;
    if (c_push) c_mem[c_wp] <= {done_ok, cur_pnum};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wp <= '0; q_rp <= '0; q_cnt <= '0;
      c_wp <= '0; c_rp <= '0; c_cnt <= '0;
      tx_en <= 1'b0; fault <= 1'b0; irq_empty <= 1'b0;
      rel_valid <= 1'b0; rel_pnum <= '0;
    end else begin
      if (q_push) q_wp <= (q_wp == QAW'(QDEPTH-1)) ? '0 : q_wp + 1'b1;
      if (q_pop)  q_rp <= (q_rp == QAW'(QDEPTH-1)) ? '0 : q_rp + 1'b1;
      q_cnt <= q_cnt + (QAW+1)'(q_push) - (QAW+1)'(q_pop);
      if (c_push) c_wp <= (c_wp == CAW'(CDEPTH-1)) ? '0 : c_wp + 1'b1;
      if (c_take) c_rp <= (c_rp == CAW'(CDEPTH-1)) ? '0 : c_rp + 1'b1;
      c_cnt <= c_cnt + (CAW+1)'(c_push) - (CAW+1)'(c_take);
      if (fire && !done_ok) begin
        tx_en <= 1'b0;
        fault <= 1'b1;
      end else if (tx_en_set) begin
        tx_en <= 1'b1;
        fault <= 1'b0;
      end
      if (q_push || empty_ack)                   irq_empty <= 1'b0;
      else if (q_pop && q_cnt == (QAW+1)'(1))    irq_empty <= 1'b1;
      rel_valid <= q_pop && auto_rel;
      rel_pnum  <= cur_pnum;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> q_cnt <= (QAW+1)'(QDEPTH)); // R1
  AST_FATAL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && cur_valid && !done_ok) |=> (!tx_en && !rel_valid && fault_valid)); // R6
  AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && cur_valid && !done_ok && !tx_en_set) |=> cur_pnum == $past(cur_pnum)); // R6
  AST_AUTO_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rel && done_valid && cur_valid && done_ok) |=> c_cnt <= $past(c_cnt)); // R3
  AST_NO_REL_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rel && done_valid) |=> !rel_valid); // R4
  AST_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !q_full) |=> !irq_empty); // R8
  AST_IGNORED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !cur_valid && !enq_valid) |=> (q_cnt == $past(q_cnt) && !rel_valid)); // R10
endmodule

// File: tb/test_tx_autorel_mgr.sv
`timescale 1ns/1ps
module test_tx_autorel_mgr;
  logic clk = 0, rst_n = 0;
  logic auto_rel = 0, enq_valid = 0, tx_en_set = 0, done_valid = 0, done_ok = 0;
  logic cf_pop = 0, empty_ack = 0;
  logic [5:0] enq_pnum = 0;
  logic q_full, q_empty, tx_en, cur_valid, rel_valid, cf_valid, cf_ok;
  logic irq_tx, irq_empty, fault_valid;
  logic [5:0] cur_pnum, rel_pnum, cf_pnum, fault_pnum;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_autorel_mgr i_tx_autorel_mgr (
    .clk(clk), .rst_n(rst_n), .auto_rel(auto_rel),
    .enq_valid(enq_valid), .enq_pnum(enq_pnum), .q_full(q_full), .q_empty(q_empty),
    .tx_en_set(tx_en_set), .tx_en(tx_en), .cur_valid(cur_valid), .cur_pnum(cur_pnum),
    .done_valid(done_valid), .done_ok(done_ok), .rel_valid(rel_valid), .rel_pnum(rel_pnum),
    .cf_valid(cf_valid), .cf_pnum(cf_pnum), .cf_ok(cf_ok), .cf_pop(cf_pop),
    .irq_tx(irq_tx), .irq_empty(irq_empty), .empty_ack(empty_ack),
    .fault_valid(fault_valid), .fault_pnum(fault_pnum));

  // op: 0 idle, 1 enqueue arg, 2 done ok, 3 done fatal, 4 tx_en_set, 5 empty_ack
  // expect: cur_valid, cur_pnum, rel_valid, irq_tx, irq_empty, tx_en
  localparam logic [19:0] VEC [14] = '{
    {3'd1, 6'd5,  1'b0, 6'd5,  4'b0000},  // R1 enqueue, disabled R2
    {3'd1, 6'd9,  1'b0, 6'd5,  4'b0000},
    {3'd1, 6'd12, 1'b0, 6'd5,  4'b0000},
    {3'd4, 6'd0,  1'b1, 6'd5,  4'b0001},  // R2
    {3'd2, 6'd0,  1'b1, 6'd9,  4'b1001},  // R3 R9
    {3'd0, 6'd0,  1'b1, 6'd9,  4'b0001},  // R3 single pulse
    {3'd3, 6'd0,  1'b0, 6'd9,  4'b0100},  // R6
    {3'd4, 6'd0,  1'b1, 6'd9,  4'b0001},  // R7
    {3'd2, 6'd0,  1'b1, 6'd12, 4'b1001},
    {3'd2, 6'd0,  1'b0, 6'd0,  4'b1011},  // R8
    {3'd0, 6'd0,  1'b0, 6'd0,  4'b0011},  // R8 held
    {3'd5, 6'd0,  1'b0, 6'd0,  4'b0001},  // R8 ack
    {3'd2, 6'd0,  1'b0, 6'd0,  4'b0001},  // R10
    {3'd1, 6'd33, 1'b1, 6'd33, 4'b0001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    enq_valid = 0; done_valid = 0; tx_en_set = 0; empty_ack = 0; cf_pop = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    step();
    step();
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    check(q_empty && !q_full && !tx_en && !cur_valid && !rel_valid && !cf_valid &&
          !irq_tx && !irq_empty && !fault_valid, "reset R1 R2", 0, 0);

    auto_rel = 1;
    for (int v = 0; v < 14; v++) begin
      logic [19:0] e;
      logic [10:0] got;
      e = VEC[v];
      case (e[19:17])
        3'd1: begin enq_valid = 1; enq_pnum = e[16:11]; end
        3'd2: begin done_valid = 1; done_ok = 1; end
        3'd3: begin done_valid = 1; done_ok = 0; end
        3'd4: tx_en_set = 1;
        3'd5: empty_ack = 1;
        default: ;
      endcase
      step();
      got = {cur_valid, cur_pnum, rel_valid, irq_tx, irq_empty, tx_en};
      check(got == e[10:0], $sformatf("vector %0d R2 R3 R6 R7 R8 R9 R10", v), got, e[10:0]);
      if (v == 4) check(rel_pnum == 6'd5, "R3 rel_pnum", rel_pnum, 5);
      if (v == 4) check(!cf_valid, "R3 no completion entry", cf_valid, 0);
      if (v == 6) check(fault_valid && fault_pnum == 6'd9, "R6 fault_pnum", fault_pnum, 9);
      if (v == 8) check(rel_pnum == 6'd9, "R7 resumed with failed packet", rel_pnum, 9);
    end

    do_reset();
    auto_rel = 0;
    for (int i = 0; i < 16; i++) begin
      enq_valid = 1; enq_pnum = 6'(10 + i);
      step();
    end
    check(q_full, "R1 full after 16", q_full, 1);
    enq_valid = 1; enq_pnum = 6'd63;
    step();
    check(q_full && cur_pnum == 6'd10, "R1 enqueue while full ignored", cur_pnum, 10);
    done_valid = 1; done_ok = 1;
    step();
    check(!cf_valid && cur_pnum == 6'd10, "R10 done while disabled", cf_valid, 0);
    tx_en_set = 1;
    step();
    for (int i = 0; i < 16; i++) begin
      check(cur_pnum == 6'(10 + i), "R1 order", cur_pnum, 10 + i);
      done_valid = 1; done_ok = 1;
      step();
      check(!rel_valid, "R4 no release", rel_valid, 0);
    end
    check(q_empty && irq_empty, "R8 empty in normal mode", irq_empty, 1);
    check(irq_tx && cf_valid, "R5 irq_tx with entries", irq_tx, 1);
    for (int i = 0; i < 16; i++) begin
      check(cf_valid && cf_ok && cf_pnum == 6'(10 + i), "R4 completion entry", cf_pnum, 10 + i);
      cf_pop = 1;
      step();
    end
    check(!cf_valid && !irq_tx, "R5 irq_tx low when drained", irq_tx, 0);

    enq_valid = 1; enq_pnum = 6'd7;
    step();
    check(!irq_empty, "R8 cleared by enqueue", irq_empty, 0);
    done_valid = 1; done_ok = 0;
    step();
    check(cf_valid && !cf_ok && cf_pnum == 6'd7, "R4 fatal entry", cf_ok, 0);
    check(!tx_en && fault_valid && fault_pnum == 6'd7 && !q_empty, "R6 halt keeps packet", fault_pnum, 7);
    cf_pop = 1;
    step();
    check(irq_tx && !cf_valid, "R5 irq_tx from pending fault", irq_tx, 1);
    tx_en_set = 1;
    step();
    check(!fault_valid && !irq_tx && cur_valid && cur_pnum == 6'd7, "R7 restart", cur_pnum, 7);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule